// File: doc/BRIEF.md
# Latched Status Interrupt Register Bank

This block holds two byte-wide status registers for a clock-synchronisation controller. Each implemented bit records an event and stays set until software clears it by writing a one to that bit.

Eight monitored input clocks each have a change bit. A change bit sets when the clock's validity flag toggles in either direction. When soft alarms are enabled, the bit also sets when the clock's soft frequency-limit alarm toggles. A further bit records any change of the DPLL operating-state field. Another bit records a new failure of the selected reference, but only while the DPLL is outside free-run and holdover.

Two interrupt-enable bytes mirror the status bytes bit for bit. The enabled, latched bits are ORed onto a single active-high interrupt request. The clock monitors, the DPLL and the validation logic sit outside this block, and their results arrive as synchronous inputs.

Top module: `lsirq_bank`

## Requirements
- R1: After reset, both status bytes (0x05, 0x06) and both enable bytes (0x07, 0x08) read 0x00, and irq_o is 0.
- R2: Toggling clk_valid_i[i], from 0 to 1 or from 1 to 0, sets that clock's change bit at the next clock edge. The bits map as follows. Indices 0..5 map to bits 5..0 of byte 0x05 with index i at bit i. Index 6 maps to bit 7 of 0x05. Index 7 maps to bit 0 of 0x06.
- R3: A toggle of soft_alarm_i[i] sets the same change bit as R2 only while soft_en_i is 1. While soft_en_i is 0, such a toggle leaves the status bytes unchanged.
- R4: Any change in the value of dpll_state_i sets bit 7 of byte 0x06. A steady state value sets nothing.
- R5: A 0-to-1 transition of ref_fail_i sets bit 6 of byte 0x06, unless dpll_state_i is 1 (free-run) or 2 (holdover). A failure input that stays high does not set the bit again after it has been cleared.
- R6: Writing a byte to 0x05 or 0x06 clears every status bit written with 1. Bits written with 0 keep their value.
- R7: If a qualifying event and a write-1-to-clear of the same bit occur in the same cycle, the bit ends up set.
- R8: irq_o is 1 exactly when some status bit is 1 and the enable bit at the same position is also 1.
- R9: The enable bytes at 0x07 and 0x08 are read/write, but only at implemented positions. Writing 0xFF reads back 0xBF at 0x07 and 0xC1 at 0x08. Bit 6 of 0x05 and bits 5..1 of 0x06 always read 0.
- R10: Reads from any address other than 0x05..0x08 return 0x00. Input levels present at reset release cause no event in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_valid_i | input | 8 | Validity flag per monitored clock |
| soft_alarm_i | input | 8 | Soft frequency-limit alarm per monitored clock |
| soft_en_i | input | 1 | Enables soft-alarm toggles as change events |
| dpll_state_i | input | 3 | DPLL operating state (1 = free-run, 2 = holdover) |
| ref_fail_i | input | 1 | Failure indication of the selected reference |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench toggles every clock validity flag in both directions and checks that the right bit sets. A design that detected only rising edges, or that swapped the index-6 and index-7 positions, would leave a bit clear or set the wrong one. It raises the reference failure in all eight DPLL states and holds the failure high across a clear. A level-sensitive or unmasked design would set the failure bit in free-run or holdover, or set it again after the clear. It lines up an event with a clear of the same bit, and toggles soft alarms with the enable off. The first case catches a clear that wins over the event; the second catches a design that remembers the disabled toggle and reports it later. Finally, it drives nonzero inputs through reset release, which would show up as spurious change bits if the previous-value registers were not primed.

// File: rtl/lsirq_pkg.sv
package lsirq_pkg;
  localparam int NCLK  = 8;
  localparam int DW    = 8;
  localparam int AW    = 8;
  localparam int SW    = 3;
  localparam int NSTAT = 2 * DW;

  localparam logic [SW-1:0] ST_FREERUN  = 3'd1;
  localparam logic [SW-1:0] ST_HOLDOVER = 3'd2;

  localparam logic [AW-1:0] A_STAT1 = 8'h05;
  localparam logic [AW-1:0] A_STAT2 = 8'h06;
  localparam logic [AW-1:0] A_IEN1  = 8'h07;
  localparam logic [AW-1:0] A_IEN2  = 8'h08;

  // implemented positions, upper byte = second status register
  localparam logic [NSTAT-1:0] IMPL_MASK = 16'hC1BF;
  localparam int BIT_STATE = 15;
  localparam int BIT_RFAIL = 14;

  // place clock change events at their register positions
  function automatic logic [NSTAT-1:0] clk_to_stat(input logic [NCLK-1:0] ev);
    logic [NSTAT-1:0] r;
    r = '0;
    for (int i = 0; i < 6; i++) r[i] = ev[i];
    r[7] = ev[6];
    r[8] = ev[7];
    return r;
  endfunction

  function automatic logic is_fr_ho(input logic [SW-1:0] st);
    return (st == ST_FREERUN) || (st == ST_HOLDOVER);
  endfunction
endpackage

// File: rtl/lsirq_evt_det.sv
module lsirq_evt_det
  import lsirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLK-1:0] clk_valid_i,
  input  logic [NCLK-1:0] soft_alarm_i,
  input  logic            soft_en_i,
  input  logic [SW-1:0]   dpll_state_i,
  input  logic            ref_fail_i,
  output logic [NCLK-1:0] clk_ev_o,
  output logic            state_ev_o,
  output logic            fail_ev_o,
  output logic            primed_o
);
  logic [NCLK-1:0] valid_q, soft_q;
  logic [SW-1:0]   state_q;
  logic            fail_q, primed_q;

  always_comb begin
    clk_ev_o   = '0;
    state_ev_o = 1'b0;
    fail_ev_o  = 1'b0;
    if (primed_q) begin
      clk_ev_o   = (clk_valid_i ^ valid_q) |
                   ({NCLK{soft_en_i}} & (soft_alarm_i ^ soft_q));
      state_ev_o = (dpll_state_i != state_q);
      fail_ev_o  = ref_fail_i & ~fail_q & ~is_fr_ho(dpll_state_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      soft_q   <= '0;
      state_q  <= '0;
      fail_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      valid_q  <= clk_valid_i;
      soft_q   <= soft_alarm_i;
      state_q  <= dpll_state_i;
      fail_q   <= ref_fail_i;
      primed_q <= 1'b1;
    end
  end

  assign primed_o = primed_q;
endmodule

// File: rtl/lsirq_w1c.sv
module lsirq_w1c #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         upd;

  always_comb begin
    upd = (set_i != '0) || (clr_i != '0);
    q_d = ((q_q & ~clr_i) | set_i) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_q <= '0;
    else if (upd) q_q <= q_d;
  end

  assign q_o = q_q;

  // R7: an event beats a clear in the same cycle
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & MASK) != '0) |=> ((q_o & $past(set_i & MASK)) == $past(set_i & MASK)));

  // R6: written ones clear when no event lands on them
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0 && set_i == '0) |=> ((q_o & $past(clr_i)) == '0));

  // R6: no write, no event, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0 && set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/lsirq_bank.sv
module lsirq_bank
  import lsirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLK-1:0] clk_valid_i,
  input  logic [NCLK-1:0] soft_alarm_i,
  input  logic            soft_en_i,
  input  logic [SW-1:0]   dpll_state_i,
  input  logic            ref_fail_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  localparam int NB = NSTAT / DW;

  logic [NCLK-1:0]  clk_ev;
  logic             state_ev, fail_ev, primed;
  logic [NSTAT-1:0] set_v, clr_v, stat, ien;
  logic [NB-1:0]    we_stat, we_ien;

  lsirq_evt_det u_evt (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_valid_i  (clk_valid_i),
    .soft_alarm_i (soft_alarm_i),
    .soft_en_i    (soft_en_i),
    .dpll_state_i (dpll_state_i),
    .ref_fail_i   (ref_fail_i),
    .clk_ev_o     (clk_ev),
    .state_ev_o   (state_ev),
    .fail_ev_o    (fail_ev),
    .primed_o     (primed)
  );

  always_comb begin
    we_stat[0] = wr_i && (addr_i == A_STAT1);
    we_stat[1] = wr_i && (addr_i == A_STAT2);
    we_ien[0]  = wr_i && (addr_i == A_IEN1);
    we_ien[1]  = wr_i && (addr_i == A_IEN2);
    set_v            = clk_to_stat(clk_ev);
    set_v[BIT_STATE] = state_ev;
    set_v[BIT_RFAIL] = fail_ev;
  end

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_byte
      logic [DW-1:0] en_q;
      assign clr_v[b*DW +: DW] = we_stat[b] ? wdata_i : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         en_q <= '0;
        else if (we_ien[b]) en_q <= wdata_i & IMPL_MASK[b*DW +: DW];
      end
      assign ien[b*DW +: DW] = en_q;
    end
  endgenerate

  lsirq_w1c #(.W(NSTAT), .MASK(IMPL_MASK)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (stat)
  );

  always_comb begin
    unique case (addr_i)
      A_STAT1: rdata_o = stat[DW-1:0];
      A_STAT2: rdata_o = stat[NSTAT-1:DW];
      A_IEN1:  rdata_o = ien[DW-1:0];
      A_IEN2:  rdata_o = ien[NSTAT-1:DW];
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat & ien);

  // R8: no enables, no request
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq_o);

  // R5: the failure bit cannot rise while in free-run or holdover
  a_r5_no_fail_in_holdover: assert property (@(posedge clk) disable iff (!rst_n)
    is_fr_ho(dpll_state_i) |=> !$rose(stat[BIT_RFAIL]));

  // R10: nothing latches in the first cycle after reset release
  a_r10_unprimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!primed && stat == '0) |=> (stat == '0));
endmodule

// File: tb/tb_lsirq_bank.sv
module tb_lsirq_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] clk_valid, soft_alarm, wdata, addr, rdata;
  logic       soft_en, ref_fail, wr, irq;
  logic [2:0] dstate;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  lsirq_bank dut (
    .clk(clk), .rst_n(rst_n), .clk_valid_i(clk_valid), .soft_alarm_i(soft_alarm),
    .soft_en_i(soft_en), .dpll_state_i(dstate), .ref_fail_i(ref_fail),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] cmap(input int i);
    if (i < 6)  return 16'(1) << i;
    if (i == 6) return 16'h0080;
    return 16'h0100;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wrb(input logic [7:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic clr_all();
    wrb(8'h05, 8'hFF);
    wrb(8'h06, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_valid = 8'hFF; soft_alarm = 8'h5A; soft_en = 1'b0;
    dstate = 3'd0; ref_fail = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state, R10 no event from levels at release
    rd(8'h05, 8'h00, "R1/R10 stat1");
    rd(8'h06, 8'h00, "R1/R10 stat2");
    rd(8'h07, 8'h00, "R1 ien1");
    rd(8'h08, 8'h00, "R1 ien2");
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 validity toggles, both directions, every clock
    for (int i = 0; i < 8; i++) begin
      for (int d = 0; d < 2; d++) begin
        logic [15:0] e;
        e = cmap(i);
        clk_valid[i] = ~clk_valid[i];
        @(negedge clk);
        rd(8'h05, e[7:0], "R2 stat1");
        rd(8'h06, e[15:8], "R2 stat2");
        clr_all();
        rd(8'h05, 8'h00, "R6 cleared1");
        rd(8'h06, 8'h00, "R6 cleared2");
      end
    end

    // R6 writing zero keeps bits
    clk_valid[0] = ~clk_valid[0];
    @(negedge clk);
    wrb(8'h05, 8'h00);
    rd(8'h05, 8'h01, "R6 write0");
    wrb(8'h05, 8'hFE);
    rd(8'h05, 8'h01, "R6 other bits");
    wrb(8'h05, 8'h01);
    rd(8'h05, 8'h00, "R6 write1");

    // R7 event and clear in the same cycle
    clk_valid[1] = ~clk_valid[1];
    wrb(8'h05, 8'h02);
    rd(8'h05, 8'h02, "R7 event wins");
    clr_all();

    // R3 soft alarms
    soft_alarm = ~soft_alarm;
    @(negedge clk);
    rd(8'h05, 8'h00, "R3 disabled1");
    rd(8'h06, 8'h00, "R3 disabled2");
    soft_en = 1'b1;
    @(negedge clk);
    rd(8'h05, 8'h00, "R3 enable alone");
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      e = cmap(i);
      soft_alarm[i] = ~soft_alarm[i];
      @(negedge clk);
      rd(8'h05, e[7:0], "R3 soft1");
      rd(8'h06, e[15:8], "R3 soft2");
      clr_all();
    end
    soft_en = 1'b0;

    // R4 state changes
    for (int s = 0; s < 8; s++) begin
      dstate = 3'(s + 1);
      @(negedge clk);
      rd(8'h06, 8'h80, "R4 state change");
      wrb(8'h06, 8'h80);
    end
    @(negedge clk);
    rd(8'h06, 8'h00, "R4 steady");

    // R5 reference failure across all states
    for (int s = 0; s < 8; s++) begin
      dstate = 3'(s);
      @(negedge clk);
      clr_all();
      ref_fail = 1'b1;
      @(negedge clk);
      rd(8'h06, (s == 1 || s == 2) ? 8'h00 : 8'h40, "R5 fail mask");
      ref_fail = 1'b0;
      @(negedge clk);
      clr_all();
    end
    dstate = 3'd0;
    @(negedge clk);
    clr_all();
    ref_fail = 1'b1;
    @(negedge clk);
    wrb(8'h06, 8'h40);
    @(negedge clk);
    rd(8'h06, 8'h00, "R5 held high no reset");
    ref_fail = 1'b0;

    // R9 enable registers
    wrb(8'h07, 8'hFF);
    wrb(8'h08, 8'hFF);
    rd(8'h07, 8'hBF, "R9 ien1");
    rd(8'h08, 8'hC1, "R9 ien2");
    rd(8'h05, 8'h00, "R9 stat1 reserved");
    rd(8'h06, 8'h00, "R9 stat2 reserved");

    // R8 interrupt combining
    chk("R8 idle", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      e = cmap(i);
      clk_valid[i] = ~clk_valid[i];
      @(negedge clk);
      chk("R8 enabled", {7'd0, irq}, 8'h01);
      if (e[7:0] != 0) wrb(8'h07, ~e[7:0]);
      else             wrb(8'h08, ~e[15:8]);
      chk("R8 masked", {7'd0, irq}, 8'h00);
      wrb(8'h07, 8'hFF);
      wrb(8'h08, 8'hFF);
      clr_all();
      chk("R8 cleared", {7'd0, irq}, 8'h00);
    end
    dstate = 3'd5;
    @(negedge clk);
    chk("R8 state bit", {7'd0, irq}, 8'h01);
    wrb(8'h08, 8'h00);
    chk("R8 state masked", {7'd0, irq}, 8'h00);
    clr_all();

    // R10 unmapped addresses
    for (int a = 0; a < 32; a++) begin
      if (a < 5 || a > 8) rd(8'(a), 8'h00, "R10 unmapped");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule